// File: doc/BRIEF.md
# Framing Word Head Detector

This block watches a received byte stream for the line framing word: three bytes of value 0xF6 in a row, then three bytes of value 0x28. When the sixth byte of that word has been accepted, it raises a head pulse for one clock. Downstream logic uses this pulse to mark the start of a frame. The block assumes that the byte boundaries are already correct.

Bytes are presented on `rx_byte` together with the qualifier `rx_valid`. Both are captured on the falling edge of `clk`. The match state machine runs on the rising edge. The matcher is strict. It counts the framing bytes matched so far, and it advances only when the next byte is exactly the one it needs. Any other valid byte takes it straight back to idle, even a byte that could begin a new word. After the word completes, the machine spends one cycle in a dedicated final state, which drives the pulse, and then returns to idle.

The byte values, the length of each run and the capture edge are parameters. With the defaults there are seven states: idle, one state for each of the three first-value bytes, and one state for each of the three second-value bytes.

Top module: `fw_head_detect`

## Requirements
- R1: While `rst` is high, `head_o` is low and the matcher is idle. After `rst` falls, a complete new framing word is needed before any head pulse.
- R2: `rx_byte` and `rx_valid` are sampled on the falling edge of `clk`. A change to them after that edge and before the next rising edge has no effect on the byte being matched.
- R3: Six valid bytes 0xF6, 0xF6, 0xF6, 0x28, 0x28, 0x28 produce exactly one head pulse. The pulse is high for one cycle, which is the cycle after the rising edge that consumes the sixth byte.
- R4: In a partly matched state, a valid byte other than the expected value returns the matcher to idle. This includes a fourth 0xF6 and a 0xF6 arriving among the 0x28 bytes. The mismatching byte does not itself begin a new word.
- R5: Cycles with `rx_valid` low leave the match progress unchanged, whatever `rx_byte` holds. A framing word whose bytes are separated by invalid cycles is still detected.
- R6: In idle, a valid 0xF6 starts a new attempt as its first byte. Any other valid byte leaves the matcher idle.
- R7: In the cycle after the head pulse, the machine returns to idle unconditionally. A byte sampled for that cycle is discarded, so a framing word sent with no gap after a completed word is not detected.
- R8: With the default parameters the match progress never exceeds six bytes, and the head pulse is always preceded by a valid 0x28 byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Data is captured on the falling edge and state is updated on the rising edge. |
| rst | input | 1 | Asynchronous reset, active high. |
| rx_byte | input | 8 | Received byte. |
| rx_valid | input | 1 | High when `rx_byte` carries a byte. |
| head_o | output | 1 | One-cycle pulse that marks a completed framing word. |

## Verification
The hardest situation to reach from the ports is the one-cycle window in the final state. The bench reaches it by sending a second framing word on the cycle right after the first word, so that its first byte lands in the discard slot. It then sends a variant with one extra leading 0xF6 to show that detection recovers. The falling-edge capture is hard to observe directly. The bench drives each framing byte, lets the falling edge pass, and then overwrites the bus with garbage before the rising edge. A detector that sampled on the rising edge would then miss the word.

// File: rtl/fw_pkg.sv
package fw_pkg;
   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_LEAD = 2'd1,
      CLS_TAIL = 2'd2
   } fw_cls_e;
endpackage

// File: rtl/fw_byte_capture.sv
// Input capture stage: falling-edge (default) or rising-edge register.
module fw_byte_capture #(
   parameter int DATA_W         = 8,
   parameter bit SAMPLE_NEGEDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] data_i,
   input  logic              valid_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o
);
   logic [DATA_W-1:0] data_q;
   logic              valid_q;

   generate
      if (SAMPLE_NEGEDGE) begin : g_neg
         always_ff @(negedge clk or posedge rst) begin
            if (rst) begin
               data_q  <= '0;
               valid_q <= 1'b0;
            end else begin
               data_q  <= data_i;
               valid_q <= valid_i;
            end
         end
      end else begin : g_pos
         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               data_q  <= '0;
               valid_q <= 1'b0;
            end else begin
               data_q  <= data_i;
               valid_q <= valid_i;
            end
         end
      end
   endgenerate

   assign data_o  = data_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/fw_byte_classify.sv
// Maps a captured byte onto the framing classes.
module fw_byte_classify #(
   parameter int              DATA_W    = 8,
   parameter logic [DATA_W-1:0] LEAD_VAL = 8'hF6,
   parameter logic [DATA_W-1:0] TAIL_VAL = 8'h28
) (
   input  logic [DATA_W-1:0] data_i,
   output fw_pkg::fw_cls_e   cls_o
);
   always_comb begin
      if (data_i == LEAD_VAL)      cls_o = fw_pkg::CLS_LEAD;
      else if (data_i == TAIL_VAL) cls_o = fw_pkg::CLS_TAIL;
      else                         cls_o = fw_pkg::CLS_NONE;
   end
endmodule

// File: rtl/fw_match_fsm.sv
// Strict sequential matcher: state k means k framing bytes matched.
module fw_match_fsm #(
   parameter int LEAD_RUN = 3,
   parameter int TAIL_RUN = 3,
   localparam int LAST_IDX = LEAD_RUN + TAIL_RUN,
   localparam int SW       = $clog2(LAST_IDX + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            valid_i,
   input  fw_pkg::fw_cls_e cls_i,
   output logic            head_o,
   output logic [SW-1:0]   state_o
);
   localparam logic [SW-1:0] ST_IDLE  = '0;
   localparam logic [SW-1:0] ST_FINAL = SW'(LAST_IDX);
   localparam logic [SW-1:0] LEAD_END = SW'(LEAD_RUN);

   logic [SW-1:0]   state_q, state_n;
   logic            head_q;
   fw_pkg::fw_cls_e want;

   assign want = (state_q < LEAD_END) ? fw_pkg::CLS_LEAD : fw_pkg::CLS_TAIL;

   always_comb begin
      state_n = state_q;
      if (state_q == ST_FINAL) begin
         state_n = ST_IDLE;
      end else if (valid_i) begin
         if (cls_i == want) state_n = state_q + 1'b1;
         else               state_n = ST_IDLE;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state_q <= ST_IDLE;
         head_q  <= 1'b0;
      end else begin
         state_q <= state_n;
         head_q  <= (state_n == ST_FINAL);
      end
   end

   assign head_o  = head_q;
   assign state_o = state_q;
endmodule

// File: rtl/fw_head_detect.sv
module fw_head_detect #(
   parameter int                DATA_W         = 8,
   parameter logic [DATA_W-1:0] LEAD_VAL       = 8'hF6,
   parameter logic [DATA_W-1:0] TAIL_VAL       = 8'h28,
   parameter int                LEAD_RUN       = 3,
   parameter int                TAIL_RUN       = 3,
   parameter bit                SAMPLE_NEGEDGE = 1'b1,
   localparam int               SW             = $clog2(LEAD_RUN + TAIL_RUN + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_valid,
   output logic              head_o
);
   generate
      if (LEAD_RUN < 1 || TAIL_RUN < 1) begin : g_bad_run
         $error("fw_head_detect: each run length must be at least one");
      end
      if (LEAD_VAL == TAIL_VAL) begin : g_bad_val
         $error("fw_head_detect: the two framing values must differ");
      end
   endgenerate

   logic [DATA_W-1:0] cap_byte;
   logic              cap_valid;
   fw_pkg::fw_cls_e   cap_cls;
   logic [SW-1:0]     fsm_state;

   fw_byte_capture #(
      .DATA_W(DATA_W), .SAMPLE_NEGEDGE(SAMPLE_NEGEDGE)
   ) cap_i (
      .clk(clk), .rst(rst), .data_i(rx_byte), .valid_i(rx_valid),
      .data_o(cap_byte), .valid_o(cap_valid)
   );

   fw_byte_classify #(
      .DATA_W(DATA_W), .LEAD_VAL(LEAD_VAL), .TAIL_VAL(TAIL_VAL)
   ) cls_i (
      .data_i(cap_byte), .cls_o(cap_cls)
   );

   fw_match_fsm #(
      .LEAD_RUN(LEAD_RUN), .TAIL_RUN(TAIL_RUN)
   ) fsm_i (
      .clk(clk), .rst(rst), .valid_i(cap_valid), .cls_i(cap_cls),
      .head_o(head_o), .state_o(fsm_state)
   );
endmodule

// File: rtl/fw_head_detect_chk.sv
module fw_head_detect_chk #(
   parameter int LEAD_RUN = 3,
   parameter int TAIL_RUN = 3,
   parameter int SW       = 3
) (
   input logic            clk,
   input logic            rst,
   input logic            cap_valid,
   input fw_pkg::fw_cls_e cap_cls,
   input logic [SW-1:0]   state,
   input logic            head
);
   localparam logic [SW-1:0] FINAL_ST = SW'(LEAD_RUN + TAIL_RUN);
   localparam logic [SW-1:0] LEAD_END = SW'(LEAD_RUN);

   always @(negedge clk) begin
      if (rst) begin
         AST_RESET_IDLE: assert (state == '0 && !head); // R1
      end
   end

   AST_HEAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      head |=> !head); // R3

   AST_MISMATCH_IDLE: assert property (@(posedge clk) disable iff (rst)
      (cap_valid && state != '0 && state != FINAL_ST &&
       cap_cls != ((state < LEAD_END) ? fw_pkg::CLS_LEAD : fw_pkg::CLS_TAIL))
      |=> state == '0); // R4

   AST_HOLD_ON_INVALID: assert property (@(posedge clk) disable iff (rst)
      (!cap_valid && state != FINAL_ST) |=> $stable(state)); // R5

   AST_FINAL_EXIT: assert property (@(posedge clk) disable iff (rst)
      state == FINAL_ST |=> state == '0); // R7

   AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst)
      state <= FINAL_ST); // R8

   AST_HEAD_AFTER_TAIL: assert property (@(posedge clk) disable iff (rst)
      $rose(head) |-> $past(cap_valid && cap_cls == fw_pkg::CLS_TAIL)); // R8
endmodule

bind fw_head_detect fw_head_detect_chk #(
   .LEAD_RUN(LEAD_RUN), .TAIL_RUN(TAIL_RUN), .SW(SW)
) chk_i (
   .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_cls(cap_cls),
   .state(fsm_state), .head(head_o)
);

// File: tb/fw_head_detect_tb_top.sv
module fw_head_detect_tb_top;
   localparam logic [7:0] LB = 8'hF6;
   localparam logic [7:0] TB = 8'h28;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] rx_byte = '0;
   logic       rx_valid = 1'b0;
   logic       head_o;

   int checks = 0, failures = 0;
   int stepn = 0, hcnt = 0, last_h = -1;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fw_head_detect dut_i (
      .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid), .head_o(head_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle: drive after rising edge, observe after falling edge
   task automatic feed(input logic [7:0] b, input logic v);
      @(posedge clk); #1;
      stepn++;
      rx_byte = b; rx_valid = v;
      @(negedge clk); #1;
      if (head_o) begin hcnt++; last_h = stepn; end
   endtask

   // drive byte, then overwrite the bus after the capture edge
   task automatic feed_late(input logic [7:0] b, input logic [7:0] junk);
      feed(b, 1'b1);
      rx_byte = junk;
   endtask

   task automatic clear_obs();
      hcnt = 0; last_h = -1;
   endtask

   task automatic word();
      for (int i = 0; i < 3; i++) feed(LB, 1'b1);
      for (int i = 0; i < 3; i++) feed(TB, 1'b1);
   endtask

   task automatic flush();
      for (int i = 0; i < 4; i++) feed(8'h00, 1'b0);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      feed(LB, 1'b1);
      chk(head_o == 1'b0, "R1 head low in reset", head_o, 0);
      feed(LB, 1'b1);
      @(posedge clk); #1; rst = 1'b0;
      clear_obs();
      for (int i = 0; i < 4; i++) feed(TB, 1'b1);
      flush();
      chk(hcnt == 0, "R1 no head without full word after reset", hcnt, 0);
   endtask

   task automatic t_basic();
      int s;
      clear_obs(); s = stepn + 1;
      word(); flush();
      chk(hcnt == 1, "R3 one pulse per word", hcnt, 1);
      chk(last_h == s + 6, "R3 pulse timing", last_h, s + 6);
   endtask

   task automatic t_mismatch();
      int s;
      clear_obs();
      feed(LB, 1'b1); feed(LB, 1'b1); feed(8'h55, 1'b1);
      s = stepn + 1; word(); flush();
      chk(hcnt == 1 && last_h == s + 6, "R4 recover after broken lead run", last_h, s + 6);
      clear_obs();
      for (int i = 0; i < 4; i++) feed(LB, 1'b1);
      for (int i = 0; i < 3; i++) feed(TB, 1'b1);
      flush();
      chk(hcnt == 0, "R4 fourth lead byte resets", hcnt, 0);
      clear_obs();
      for (int i = 0; i < 3; i++) feed(LB, 1'b1);
      feed(TB, 1'b1); feed(TB, 1'b1); feed(LB, 1'b1); feed(TB, 1'b1);
      flush();
      chk(hcnt == 0, "R4 lead byte among tail bytes resets", hcnt, 0);
   endtask

   task automatic t_gaps();
      int s;
      clear_obs();
      for (int i = 0; i < 6; i++) begin
         feed((i < 3) ? LB : TB, 1'b1);
         feed(8'h13, 1'b0);
         feed((i < 3) ? TB : LB, 1'b0);
      end
      s = stepn;
      flush();
      chk(hcnt == 1 && last_h == s - 1, "R5 word with invalid gaps", last_h, s - 1);
      clear_obs();
      for (int i = 0; i < 3; i++) feed(LB, 1'b0);
      for (int i = 0; i < 3; i++) feed(TB, 1'b0);
      flush();
      chk(hcnt == 0, "R5 invalid bytes ignored", hcnt, 0);
   endtask

   task automatic t_idle_start();
      int s;
      clear_obs();
      feed(8'h00, 1'b1); feed(TB, 1'b1); feed(8'hFF, 1'b1); feed(TB, 1'b1);
      s = stepn + 1; word(); flush();
      chk(hcnt == 1 && last_h == s + 6, "R6 noise in idle then word", last_h, s + 6);
   endtask

   task automatic t_back_to_back();
      int s;
      clear_obs();
      word(); word(); flush();
      chk(hcnt == 1, "R7 word right after word lost", hcnt, 1);
      clear_obs();
      word(); s = stepn + 2;
      feed(LB, 1'b1); word(); flush();
      chk(hcnt == 2, "R7 discard slot then word: two pulses", hcnt, 2);
      chk(last_h == s + 6, "R7 second pulse timing", last_h, s + 6);
   endtask

   task automatic t_late_change();
      int s;
      clear_obs(); s = stepn + 1;
      for (int i = 0; i < 3; i++) feed_late(LB, 8'h00);
      for (int i = 0; i < 3; i++) feed_late(TB, 8'hA5);
      flush();
      chk(hcnt == 1 && last_h == s + 6, "R2 falling-edge sampling", last_h, s + 6);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_mismatch();
      t_gaps();
      t_idle_start();
      t_back_to_back();
      t_late_change();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule